// File: doc/BRIEF.md
# Row-Buffered SRAM Access Controller

This block connects a narrow host port (word address, 16-bit data, read and write strobes) to a wide SRAM array that can only be read or written one full 128-bit row at a time. Every row that comes out of the array is kept in a row-wide holding register, and a tag records which bank and row it holds. A later host read that lands in the held row is answered from the register. It makes no array access, so the bank and row decoders and the word lines stay idle. After one full array read of a row, the remaining seven words of that row can each be read at this low cost.

The array has no column multiplexer, so a host write cannot touch a single word. The controller fetches the target row, merges the new 16-bit word into it, writes all 128 bits back, and keeps the merged row in the holding register. Later hits therefore return the new data. Each finished access pulses `done_o` together with an event code, so the cost of each access can be counted outside the block.

Top module: `row_buf_ctrl`

## Requirements
- R1: After reset `ready_o` is high, `done_o` is low, neither array strobe is active, and the holding register is marked empty, so the first read always goes to the array.
- R2: The host address splits into bank = addr[10:9], row = addr[8:3] and word = addr[2:0]. Word k occupies row bits [16k+15:16k], so word 0 sits in bits [15:0].
- R3: A read that misses the held row produces exactly one `arr_rd_o` cycle and no `arr_wr_o`. It returns the word with `done_o` three cycles after the request edge, with `evt_o` = 1 (full read).
- R4: A read whose bank and row match a valid held row causes no array strobe. It returns the word with `done_o` one cycle after the request edge, with `evt_o` = 2 (low-energy read).
- R5: After a full read of a row, reads of the other seven words of that row are all low-energy reads.
- R6: A write produces one `arr_rd_o` cycle and, two cycles later, one `arr_wr_o` cycle that carries the whole row. Only the addressed word changes. `done_o` comes four cycles after the request edge, with `evt_o` = 3 (write).
- R7: After a write, the holding register holds the merged row and its tag, so reads of that row are low-energy reads that return the written data.
- R8: Strobes presented while `ready_o` is low are ignored and change no memory contents.
- R9: When `rd_i` and `wr_i` are both high at an accepted edge, the access is a write.
- R10: `arr_rd_o` and `arr_wr_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Host read strobe, sampled while ready_o is high |
| wr_i | input | 1 | Host write strobe, sampled while ready_o is high |
| addr_i | input | 11 | Host word address |
| wdata_i | input | 16 | Host write word |
| ready_o | output | 1 | Controller idle, accepts a strobe |
| rdata_o | output | 16 | Read word, valid with done_o on reads |
| done_o | output | 1 | Access finished this cycle |
| evt_o | output | 2 | Event code with done_o: 1 full read, 2 low-energy read, 3 write |
| arr_bank_o | output | 2 | Array bank select |
| arr_row_o | output | 6 | Array row index within the bank |
| arr_rd_o | output | 1 | Array row read; data returns on arr_rdata_i next cycle |
| arr_wr_o | output | 1 | Array row write of arr_wdata_o |
| arr_wdata_o | output | 128 | Row written to the array |
| arr_rdata_i | input | 128 | Row read from the array |

## Verification
The bench builds the block with its default parameters: 11-bit address, 16-bit words and 128-bit rows. That gives eight words per row and 256 rows over four banks, small enough for the bench to hold a full array model and a word-level shadow copy. Random addresses are drawn from a few rows in each bank, so hits, misses, row replacement and writes to the held row all occur many times. Directed sequences cover a full sweep of one row, the decode of a specific bank, row and word, simultaneous strobes, and strobes sent while the controller is busy.

// File: rtl/rbc_pkg.sv
package rbc_pkg;
  typedef enum logic [1:0] {
    EVT_NONE  = 2'd0,
    EVT_FULL  = 2'd1,
    EVT_LOW   = 2'd2,
    EVT_WRITE = 2'd3
  } evt_e;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_FETCH   = 2'd1,
    ST_CAPTURE = 2'd2,
    ST_WRBACK  = 2'd3
  } st_e;
endpackage

// File: rtl/rbc_tag.sv
module rbc_tag #(
  parameter int TAG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0] probe_i,
  output logic             hit_o
);
  logic             valid_q;
  logic [TAG_W-1:0] tag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      tag_q   <= tag_i;
    end
  end

  assign hit_o = valid_q && (tag_q == probe_i);
endmodule

// File: rtl/rbc_row_latch.sv
module rbc_row_latch #(
  parameter int ROW_W  = 128,
  parameter int WORD_W = 16,
  localparam int NWORD = ROW_W / WORD_W,
  localparam int SEL_W = $clog2(NWORD)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              merge_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [WORD_W-1:0] held_word_o,
  output logic [WORD_W-1:0] fresh_word_o
);
  logic [ROW_W-1:0] row_q;
  logic [ROW_W-1:0] merged;

  for (genvar w = 0; w < NWORD; w++) begin : g_merge
    assign merged[w*WORD_W +: WORD_W] =
      (merge_i && (sel_i == SEL_W'(w))) ? wdata_i : row_i[w*WORD_W +: WORD_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) row_q <= '0;
    else if (load_i) row_q <= merged;
  end

  assign row_o        = row_q;
  assign held_word_o  = row_q[sel_i*WORD_W +: WORD_W];
  assign fresh_word_o = row_i[sel_i*WORD_W +: WORD_W];
endmodule

// File: rtl/rbc_fsm.sv
module rbc_fsm
  import rbc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rd_i,
  input  logic       wr_i,
  input  logic       hit_i,
  output st_e        st_o,
  output logic       is_wr_o,
  output logic       start_o,
  output logic       hit_rd_o,
  output logic       done_o,
  output logic [1:0] evt_o
);
  st_e  st_q, st_d;
  logic is_wr_q;
  logic idle;
  logic done_d;
  evt_e evt_d, evt_q;

  assign idle     = (st_q == ST_IDLE);
  assign hit_rd_o = idle && rd_i && !wr_i && hit_i;
  assign start_o  = idle && (wr_i || (rd_i && !hit_i));

  always_comb begin
    st_d   = st_q;
    done_d = 1'b0;
    evt_d  = EVT_NONE;
    unique case (st_q)
      ST_IDLE: begin
        if (start_o) st_d = ST_FETCH;
        else if (hit_rd_o) begin
          done_d = 1'b1;
          evt_d  = EVT_LOW;
        end
      end
      ST_FETCH:   st_d = ST_CAPTURE;
      ST_CAPTURE: begin
        if (is_wr_q) st_d = ST_WRBACK;
        else begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          evt_d  = EVT_FULL;
        end
      end
      ST_WRBACK: begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
        evt_d  = EVT_WRITE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      is_wr_q <= 1'b0;
      done_o  <= 1'b0;
      evt_q   <= EVT_NONE;
    end else begin
      st_q   <= st_d;
      done_o <= done_d;
      evt_q  <= evt_d;
      if (start_o) is_wr_q <= wr_i;
    end
  end

  assign st_o    = st_q;
  assign is_wr_o = is_wr_q;
  assign evt_o   = evt_q;
endmodule

// File: rtl/row_buf_ctrl.sv
module row_buf_ctrl
  import rbc_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int WORD_W = 16,
  parameter int ROW_W  = 128,
  parameter int BANK_W = 2,
  localparam int NWORD = ROW_W / WORD_W,
  localparam int SEL_W = $clog2(NWORD),
  localparam int RIDX_W = ADDR_W - BANK_W - SEL_W,
  localparam int TAG_W = BANK_W + RIDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              done_o,
  output logic [1:0]        evt_o,
  output logic [BANK_W-1:0] arr_bank_o,
  output logic [RIDX_W-1:0] arr_row_o,
  output logic              arr_rd_o,
  output logic              arr_wr_o,
  output logic [ROW_W-1:0]  arr_wdata_o,
  input  logic [ROW_W-1:0]  arr_rdata_i
);
  st_e               st;
  logic              is_wr, start, hit_rd, hit;
  logic [ADDR_W-1:0] req_addr_q;
  logic [WORD_W-1:0] req_data_q;
  logic [SEL_W-1:0]  sel;
  logic [WORD_W-1:0] held_word, fresh_word;
  logic              capture;

  assign ready_o = (st == ST_IDLE);
  assign capture = (st == ST_CAPTURE);
  // idle: word select follows the live address for hits
  assign sel = ready_o ? addr_i[SEL_W-1:0] : req_addr_q[SEL_W-1:0];

  rbc_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_i    (rd_i),
    .wr_i    (wr_i),
    .hit_i   (hit),
    .st_o    (st),
    .is_wr_o (is_wr),
    .start_o (start),
    .hit_rd_o(hit_rd),
    .done_o  (done_o),
    .evt_o   (evt_o)
  );

  rbc_tag #(.TAG_W(TAG_W)) u_tag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (capture),
    .tag_i  (req_addr_q[ADDR_W-1:SEL_W]),
    .probe_i(addr_i[ADDR_W-1:SEL_W]),
    .hit_o  (hit)
  );

  rbc_row_latch #(.ROW_W(ROW_W), .WORD_W(WORD_W)) u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (capture),
    .merge_i     (is_wr),
    .row_i       (arr_rdata_i),
    .sel_i       (sel),
    .wdata_i     (req_data_q),
    .row_o       (arr_wdata_o),
    .held_word_o (held_word),
    .fresh_word_o(fresh_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_addr_q <= '0;
      req_data_q <= '0;
      rdata_o    <= '0;
    end else begin
      if (start) begin
        req_addr_q <= addr_i;
        req_data_q <= wdata_i;
      end
      if (hit_rd) rdata_o <= held_word;
      else if (capture && !is_wr) rdata_o <= fresh_word;
    end
  end

  assign arr_bank_o = req_addr_q[ADDR_W-1 -: BANK_W];
  assign arr_row_o  = req_addr_q[SEL_W +: RIDX_W];
  assign arr_rd_o   = (st == ST_FETCH);
  assign arr_wr_o   = (st == ST_WRBACK);
endmodule

// File: rtl/rbc_chk.sv
module rbc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ready_o,
  input logic       done_o,
  input logic [1:0] evt_o,
  input logic       arr_rd_o,
  input logic       arr_wr_o
);
  // R10
  excl_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(arr_rd_o && arr_wr_o));

  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!arr_rd_o && !arr_wr_o));

  // R4
  low_no_array_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && evt_o == 2'd2) |-> $past(!arr_rd_o && !arr_wr_o));

  // R3
  full_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && evt_o == 2'd1) |-> $past(arr_rd_o, 2));

  // R6
  wr_after_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_wr_o |-> $past(arr_rd_o, 2));

  // R6
  wr_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && evt_o == 2'd3) |-> $past(arr_wr_o));
endmodule

bind row_buf_ctrl rbc_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .ready_o (ready_o),
  .done_o  (done_o),
  .evt_o   (evt_o),
  .arr_rd_o(arr_rd_o),
  .arr_wr_o(arr_wr_o)
);

// File: tb/sim_row_buf_ctrl.sv
module sim_row_buf_ctrl;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         rd_i = 1'b0, wr_i = 1'b0;
  logic [10:0]  addr_i = '0;
  logic [15:0]  wdata_i = '0;
  logic         ready_o, done_o, arr_rd_o, arr_wr_o;
  logic [15:0]  rdata_o;
  logic [1:0]   evt_o;
  logic [1:0]   arr_bank_o;
  logic [5:0]   arr_row_o;
  logic [127:0] arr_wdata_o;
  logic [127:0] arr_rdata_i;

  int errors = 0, checks = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [127:0] amem [256];
  logic [15:0]  ref_mem [2048];
  logic         exp_valid = 1'b0;
  logic [7:0]   exp_tag = '0;

  always #10 clk_i = ~clk_i;

  row_buf_ctrl u0 (.*);

  always @(posedge clk_i) begin
    if (arr_rd_o) begin
      arr_rdata_i <= amem[{arr_bank_o, arr_row_o}];
      rd_cnt <= rd_cnt + 1;
    end
    if (arr_wr_o) begin
      amem[{arr_bank_o, arr_row_o}] <= arr_wdata_o;
      wr_cnt <= wr_cnt + 1;
    end
  end

  function automatic logic [15:0] seed_word(int i);
    return 16'(i * 16'h9e37 ^ 16'h5a5a);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(bit wr, bit rd, logic [10:0] a, logic [15:0] d, string req);
    int lat = 1;
    int r0, w0;
    bit hit;
    int exp_lat;
    logic [1:0] exp_evt;
    bit as_wr = wr;
    hit = !as_wr && exp_valid && exp_tag == a[10:3];
    exp_lat = as_wr ? 4 : (hit ? 1 : 3);
    exp_evt = as_wr ? 2'd3 : (hit ? 2'd2 : 2'd1);
    @(negedge clk_i);
    r0 = rd_cnt; w0 = wr_cnt;
    rd_i = rd; wr_i = wr; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    rd_i = 0; wr_i = 0;
    while (!done_o && lat < 20) begin
      @(negedge clk_i);
      lat++;
    end
    chk(lat == exp_lat, req, lat, exp_lat);
    chk(evt_o == exp_evt, req, evt_o, exp_evt);
    chk(rd_cnt - r0 == (hit ? 0 : 1), req, rd_cnt - r0, hit ? 0 : 1);
    chk(wr_cnt - w0 == (as_wr ? 1 : 0), req, wr_cnt - w0, as_wr ? 1 : 0);
    if (as_wr) begin
      ref_mem[a] = d;
      for (int k = 0; k < 8; k++)
        chk(amem[a[10:3]][k*16 +: 16] == ref_mem[{a[10:3], 3'(k)}], req,
            amem[a[10:3]][k*16 +: 16], ref_mem[{a[10:3], 3'(k)}]);
    end else begin
      chk(rdata_o == ref_mem[a], req, rdata_o, ref_mem[a]);
    end
    exp_valid = 1'b1;
    exp_tag = a[10:3];
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int r0, w0;
    void'($urandom(32'd4242));
    for (int i = 0; i < 2048; i++) ref_mem[i] = seed_word(i);
    for (int r = 0; r < 256; r++)
      for (int k = 0; k < 8; k++) amem[r][k*16 +: 16] = seed_word(r * 8 + k);
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(ready_o == 1 && done_o == 0, "R1", {ready_o, done_o}, 2'b10);
    chk(!arr_rd_o && !arr_wr_o, "R1", {arr_rd_o, arr_wr_o}, 0);
    rst_ni = 1'b1;
    // R1 first read misses; R3 full read; R5 sweep of the row
    access(0, 1, {2'd1, 6'd9, 3'd0}, 0, "R1 R3");
    for (int k = 1; k < 8; k++) access(0, 1, {2'd1, 6'd9, 3'(k)}, 0, "R4 R5");
    // R2 decode: bank 2, row 5, word 3 lands in bits [63:48]
    access(1, 0, {2'd2, 6'd5, 3'd3}, 16'hbeef, "R6");
    chk(amem[{2'd2, 6'd5}][63:48] == 16'hbeef, "R2", amem[{2'd2, 6'd5}][63:48], 16'hbeef);
    // R7 hits after write see merged data
    access(0, 1, {2'd2, 6'd5, 3'd3}, 0, "R7");
    access(0, 1, {2'd2, 6'd5, 3'd0}, 0, "R7");
    // R9 both strobes => write
    access(1, 1, {2'd0, 6'd1, 3'd7}, 16'h1234, "R9");
    access(0, 1, {2'd0, 6'd1, 3'd7}, 0, "R9");
    // R8 strobes while busy are ignored
    @(negedge clk_i);
    r0 = rd_cnt; w0 = wr_cnt;
    rd_i = 1; addr_i = {2'd3, 6'd20, 3'd2};
    @(negedge clk_i);
    chk(ready_o == 0, "R8", ready_o, 0);
    rd_i = 0; wr_i = 1; addr_i = {2'd3, 6'd21, 3'd4}; wdata_i = 16'hdead;
    @(negedge clk_i);
    wr_i = 0;
    while (!done_o) @(negedge clk_i);
    chk(rdata_o == ref_mem[{2'd3, 6'd20, 3'd2}], "R8", rdata_o, ref_mem[{2'd3, 6'd20, 3'd2}]);
    @(negedge clk_i);
    chk(wr_cnt == w0 && rd_cnt == r0 + 1, "R8", wr_cnt - w0, 0);
    exp_tag = {2'd3, 6'd20};
    access(0, 1, {2'd3, 6'd21, 3'd4}, 0, "R8");
    // R10 random mix (also covered by assertion)
    for (int i = 0; i < 400; i++) begin
      logic [10:0] a;
      bit w;
      a = {2'($urandom), 6'($urandom_range(0, 3)), 3'($urandom)};
      w = ($urandom_range(0, 3) == 0);
      access(w, !w, a, 16'($urandom), w ? "R6" : "R3 R4");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule